// File: doc/BRIEF.md
# Adaptive Binary Range Decoder

This block turns a compressed byte stream into binary decisions with an arithmetic range decoder. Bytes enter on a valid/ready port. After reset the decoder first takes five bytes to fill its 32-bit code register. It then accepts commands, one at a time, on a second valid/ready port.

A command either decodes a single bit or decodes a run of bits. For a single bit, the command carries an 11-bit adaptive probability, and the response returns that probability updated. For a run, the bits are equiprobable, need no probability, and are packed into one word.

The probability tables live outside the block. The caller passes a probability in with each command and writes the returned value back to its table. Whenever the decoder needs a byte and none is offered, it waits, holding all of its state, and continues once the byte arrives. A finish flag tells the caller whether the code register is zero, which is the condition for a correctly terminated stream.

Top module: `rc_bit_decoder`

## Requirements
- R1: Reset sets range to 0xFFFFFFFF, clears code and arms a five-byte fill. After reset, in_ready is 1 and cmd_ready, init_done, init_error, finish_ok and rsp_done are all 0.
- R2: The five fill bytes enter code from the bottom, one per handshake (code = code<<8 | byte). init_done rises after the fifth byte. Before that, cmd_ready stays 0, commands are not taken and no response is produced.
- R3: If the first fill byte is not 0x00, that byte is the only one consumed. init_error then goes to 1 and stays at 1 until reset, with in_ready, cmd_ready and init_done all held at 0.
- R4: Before every decoded bit, the decoder checks range against 2^24. If range is below 2^24, exactly one input byte is consumed: range shifts left by 8 and code becomes code<<8 | byte. If range is at or above 2^24, no byte is consumed.
- R5: A command with cmd_direct = 0 computes bound = (range>>11)*cmd_prob. If code < bound, the bit is 0 and range becomes bound. Otherwise the bit is 1 and both range and code are reduced by bound. The bit appears on rsp_bit and on bit 0 of rsp_value.
- R6: For a cmd_direct = 0 command, rsp_prob is the adapted probability. It is prob + ((2048 - prob)>>5) when the bit is 0 and prob - (prob>>5) when the bit is 1.
- R7: A command with cmd_direct = 1 decodes cmd_count bits; a count of 0 decodes one bit. For each bit, range is halved and then subtracted from code. If the sign bit of the result is set, the bit is 0 and code is left unchanged. Otherwise the bit is 1 and code keeps the difference. Each bit enters rsp_value from the bottom, so the first bit ends up as the most significant of the run.
- R8: If a byte is needed and in_valid is low, the decoder waits with its state unchanged and produces no response. The final result is the same as with an uninterrupted input.
- R9: Every command produces exactly one rsp_done pulse, one cycle long. cmd_ready is 1 only while the decoder is idle, and it is never 1 in the same cycle as in_ready.
- R10: finish_ok is 1 exactly when initialisation has completed and code equals zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input byte offered |
| in_data | input | 8 | Input byte |
| in_ready | output | 1 | Decoder takes the offered byte |
| cmd_valid | input | 1 | Command offered |
| cmd_direct | input | 1 | 0: one adaptive bit, 1: run of equiprobable bits |
| cmd_prob | input | 11 | Probability of a 0 bit, scaled to 2048 |
| cmd_count | input | 6 | Number of bits in a run (0 means 1) |
| cmd_ready | output | 1 | Decoder takes the command |
| rsp_done | output | 1 | One-cycle response strobe |
| rsp_bit | output | 1 | Decoded bit (last bit of a run) |
| rsp_value | output | 32 | Decoded bit or packed run of bits |
| rsp_prob | output | 11 | Adapted probability |
| init_done | output | 1 | Five-byte fill completed |
| init_error | output | 1 | First fill byte was non-zero |
| finish_ok | output | 1 | Initialised and code is zero |

## Verification
The hardest case to reach from the ports is a stall in the middle of a run of bits. The byte has to be missing at the exact moment range drops below 2^24, partway through the loop. The bench reaches this state in two ways. First, it withholds all input while a 32-bit run is pending, checks that no response appears and no byte is taken, and only then releases the stream. Second, it throttles the byte feeder to one offer every few cycles, so that stalls land at varied points in runs of every length. In both cases, each result and the count of consumed bytes are compared against an arithmetic model that reads the same stream.

// File: rtl/rc_bit_decoder.sv
`timescale 1ns/1ps
module rc_bit_decoder #(
  parameter int WORD_W      = 32,
  parameter int BYTE_W      = 8,
  parameter int PROB_BITS   = 11,
  parameter int ADAPT_SHIFT = 5,
  parameter int CNT_W       = 6,
  parameter int INIT_BYTES  = 5
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_valid,
  input  logic [BYTE_W-1:0]    in_data,
  output logic                 in_ready,
  input  logic                 cmd_valid,
  input  logic                 cmd_direct,
  input  logic [PROB_BITS-1:0] cmd_prob,
  input  logic [CNT_W-1:0]     cmd_count,
  output logic                 cmd_ready,
  output logic                 rsp_done,
  output logic                 rsp_bit,
  output logic [WORD_W-1:0]    rsp_value,
  output logic [PROB_BITS-1:0] rsp_prob,
  output logic                 init_done,
  output logic                 init_error,
  output logic                 finish_ok
);
  localparam int IW = $clog2(INIT_BYTES + 1);
  localparam logic [PROB_BITS:0] TOTAL = {1'b1, {PROB_BITS{1'b0}}};

  typedef enum logic [2:0] {S_FILL, S_IDLE, S_NORM, S_EXEC, S_FAIL} st_t;

  st_t                  st;
  logic [WORD_W-1:0]    rng, cod, acc;
  logic [IW-1:0]        fill_left;
  logic                 is_dir;
  logic [PROB_BITS-1:0] prob_q;
  logic [CNT_W-1:0]     cnt_q;

  logic                 need_byte;
  logic [WORD_W-1:0]    bound, half, trial;
  logic                 zero_bit, dbit;
  logic [PROB_BITS:0]   up_diff, up_step;
  logic [PROB_BITS-1:0] prob_up, prob_dn;

  assign need_byte  = (rng[WORD_W-1 -: BYTE_W] == '0);
  assign in_ready   = (st == S_FILL) || (st == S_NORM && need_byte);
  assign cmd_ready  = (st == S_IDLE);
  assign init_done  = (st != S_FILL) && (st != S_FAIL);
  assign init_error = (st == S_FAIL);
  assign finish_ok  = init_done && (cod == '0);

  assign bound    = (rng >> PROB_BITS) * {{(WORD_W-PROB_BITS){1'b0}}, prob_q};
  assign zero_bit = (cod < bound);
  assign up_diff  = TOTAL - {1'b0, prob_q};
  assign up_step  = up_diff >> ADAPT_SHIFT;
  assign prob_up  = prob_q + up_step[PROB_BITS-1:0];
  assign prob_dn  = prob_q - (prob_q >> ADAPT_SHIFT);

  assign half  = rng >> 1;
  assign trial = cod - half;
  assign dbit  = ~trial[WORD_W-1];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st        <= S_FILL;
      rng       <= '1;
      cod       <= '0;
      acc       <= '0;
      fill_left <= IW'(INIT_BYTES);
      is_dir    <= 1'b0;
      prob_q    <= '0;
      cnt_q     <= '0;
      rsp_done  <= 1'b0;
      rsp_bit   <= 1'b0;
      rsp_value <= '0;
      rsp_prob  <= '0;
    end else begin
      rsp_done <= 1'b0;
      case (st)
        S_FILL: if (in_valid) begin
          if (fill_left == IW'(INIT_BYTES) && in_data != '0) begin
            st <= S_FAIL;
          end else begin
            cod       <= {cod[WORD_W-BYTE_W-1:0], in_data};
            fill_left <= fill_left - IW'(1);
            if (fill_left == IW'(1)) st <= S_IDLE;
          end
        end
        S_IDLE: if (cmd_valid) begin
          is_dir <= cmd_direct;
          prob_q <= cmd_prob;
          cnt_q  <= cmd_count;
          acc    <= '0;
          st     <= S_NORM;
        end
        S_NORM: begin
          if (!need_byte) begin
            st <= S_EXEC;
          end else if (in_valid) begin
            rng <= rng << BYTE_W;
            cod <= {cod[WORD_W-BYTE_W-1:0], in_data};
            st  <= S_EXEC;
          end
        end
        S_EXEC: begin
          if (!is_dir) begin
            if (zero_bit) begin
              rng      <= bound;
              rsp_prob <= prob_up;
            end else begin
              rng      <= rng - bound;
              cod      <= cod - bound;
              rsp_prob <= prob_dn;
            end
            rsp_bit   <= ~zero_bit;
            rsp_value <= {{(WORD_W-1){1'b0}}, ~zero_bit};
            rsp_done  <= 1'b1;
            st        <= S_IDLE;
          end else begin
            rng <= half;
            if (dbit) cod <= trial;
            acc <= {acc[WORD_W-2:0], dbit};
            if (cnt_q <= CNT_W'(1)) begin
              rsp_bit   <= dbit;
              rsp_value <= {acc[WORD_W-2:0], dbit};
              rsp_prob  <= prob_q;
              rsp_done  <= 1'b1;
              st        <= S_IDLE;
            end else begin
              cnt_q <= cnt_q - CNT_W'(1);
              st    <= S_NORM;
            end
          end
        end
        default: st <= S_FAIL;
      endcase
    end
  end

  a_r4_range_normalised: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_EXEC) |-> !need_byte);

  a_r9_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_done |=> !rsp_done);

  a_r9_ready_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(cmd_ready && in_ready));

  a_r2_no_cmd_before_fill: assert property (@(posedge clk) disable iff (!rst_n)
    !init_done |-> !cmd_ready);

  a_r3_error_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    init_error |=> init_error);

  a_r6_prob_rises_on_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_done && !is_dir && !rsp_bit) |-> (rsp_prob >= prob_q));

  a_r6_prob_falls_on_one: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_done && !is_dir && rsp_bit) |-> (rsp_prob <= prob_q));

  a_r8_stall_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_NORM && need_byte && !in_valid) |=>
      ($stable(rng) && $stable(cod) && st == S_NORM && !rsp_done));
endmodule

// File: tb/test_rc_bit_decoder.sv
`timescale 1ns/1ps
module test_rc_bit_decoder;
  localparam int N = 4096;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [7:0]  in_data = '0;
  logic        in_ready;
  logic        cmd_valid = 1'b0;
  logic        cmd_direct = 1'b0;
  logic [10:0] cmd_prob = '0;
  logic [5:0]  cmd_count = '0;
  logic        cmd_ready, rsp_done, rsp_bit, init_done, init_error, finish_ok;
  logic [31:0] rsp_value;
  logic [10:0] rsp_prob;

  rc_bit_decoder i_rc_bit_decoder (
    .clk(clk), .rst_n(rst_n),
    .in_valid(in_valid), .in_data(in_data), .in_ready(in_ready),
    .cmd_valid(cmd_valid), .cmd_direct(cmd_direct), .cmd_prob(cmd_prob),
    .cmd_count(cmd_count), .cmd_ready(cmd_ready),
    .rsp_done(rsp_done), .rsp_bit(rsp_bit), .rsp_value(rsp_value),
    .rsp_prob(rsp_prob), .init_done(init_done), .init_error(init_error),
    .finish_ok(finish_ok)
  );

  always #5 clk = ~clk;

  logic [7:0]  stream [N];
  int          fptr = 0;
  int          cyc = 0;
  int          gap = 0;
  bit          hold = 1'b1;
  bit          take;
  int          errors = 0;
  int          checks = 0;
  logic [31:0] m_rng, m_cod;
  int          m_ptr;

  initial begin
    forever begin
      @(negedge clk);
      cyc++;
      in_valid = !hold && (fptr < N) && (gap == 0 || (cyc % gap) == 0);
      in_data  = stream[fptr % N];
      #4;
      take = in_valid && in_ready && rst_n;
      @(posedge clk);
      if (take) fptr++;
    end
  end

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic fill(input logic [31:0] seed);
    logic [31:0] s = seed;
    for (int i = 0; i < N; i++) begin
      s ^= s << 13; s ^= s >> 17; s ^= s << 5;
      stream[i] = s[7:0];
    end
    stream[0] = 8'h00;
    stream[1] = stream[1] & 8'h7F;
  endtask

  function automatic void m_norm();
    if (m_rng < 32'h0100_0000) begin
      m_rng = m_rng << 8;
      m_cod = (m_cod << 8) | {24'b0, stream[m_ptr]};
      m_ptr++;
    end
  endfunction

  task automatic do_reset();
    hold = 1'b1;
    @(negedge clk);
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    fptr  = 0;
    m_ptr = 5;
    m_rng = 32'hFFFF_FFFF;
    m_cod = {stream[1], stream[2], stream[3], stream[4]};
    rst_n = 1'b1;
  endtask

  task automatic wait_init();
    for (int i = 0; i < 100; i++) begin
      @(negedge clk);
      if (init_done) break;
    end
  endtask

  task automatic send_cmd(input bit dir, input int p, input int n);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_direct = dir; cmd_prob = 11'(p); cmd_count = 6'(n);
    for (int i = 0; i < 1000; i++) begin
      #4;
      if (cmd_ready) break;
      @(negedge clk);
    end
    @(posedge clk);
    #1 cmd_valid = 1'b0;
  endtask

  task automatic get_rsp(output bit ok);
    ok = 1'b0;
    for (int i = 0; i < 4000; i++) begin
      @(negedge clk);
      if (rsp_done) begin ok = 1'b1; break; end
    end
  endtask

  task automatic do_bit(input int p);
    bit ok; logic [31:0] b; int eb, ep;
    send_cmd(1'b0, p, 0);
    get_rsp(ok);
    chk(ok, "R9 response pulse for bit command", ok, 1);
    m_norm();
    b = (m_rng >> 11) * 32'(p);
    if (m_cod < b) begin m_rng = b; eb = 0; ep = p + ((2048 - p) >> 5); end
    else begin m_rng -= b; m_cod -= b; eb = 1; ep = p - (p >> 5); end
    chk(rsp_bit == eb[0], "R5 decoded bit", rsp_bit, eb);
    chk(rsp_value == 32'(eb), "R5 bit on rsp_value", rsp_value, eb);
    chk(rsp_prob == 11'(ep), "R6 adapted probability", rsp_prob, ep);
    chk(fptr == m_ptr, "R4 bytes consumed", fptr, m_ptr);
  endtask

  task automatic do_dir(input int n);
    bit ok; logic [31:0] v, t; int k;
    send_cmd(1'b1, 0, n);
    get_rsp(ok);
    chk(ok, "R9 response pulse for run command", ok, 1);
    k = (n == 0) ? 1 : n;
    v = 0;
    for (int i = 0; i < k; i++) begin
      m_norm();
      m_rng = m_rng >> 1;
      t = m_cod - m_rng;
      if (t[31]) v = v << 1;
      else begin m_cod = t; v = (v << 1) | 32'd1; end
    end
    chk(rsp_value == v, "R7 run value", rsp_value, v);
    chk(fptr == m_ptr, "R4 bytes consumed in run", fptr, m_ptr);
  endtask

  initial begin
    #1_500_000;
    chk(1'b0, "watchdog expired", 0, 1);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    bit ok; bit saw; bit stalled; int p0; int prob;
    fill(32'h1234_5678);
    do_reset();
    @(negedge clk);
    chk(in_ready == 1'b1, "R1 in_ready after reset", in_ready, 1);
    chk(cmd_ready == 1'b0, "R1 cmd_ready after reset", cmd_ready, 0);
    chk(init_done == 1'b0, "R1 init_done after reset", init_done, 0);
    chk(init_error == 1'b0, "R1 init_error after reset", init_error, 0);
    chk(finish_ok == 1'b0, "R1 finish_ok after reset", finish_ok, 0);
    chk(rsp_done == 1'b0, "R1 rsp_done after reset", rsp_done, 0);

    cmd_valid = 1'b1;
    saw = 1'b0;
    repeat (6) begin
      @(negedge clk);
      if (rsp_done || cmd_ready) saw = 1'b1;
    end
    cmd_valid = 1'b0;
    chk(!saw, "R2 command ignored before fill", saw, 0);

    stream[0] = 8'h5A;
    hold = 1'b0;
    repeat (12) @(negedge clk);
    chk(init_error == 1'b1, "R3 error on non-zero first byte", init_error, 1);
    chk(init_done == 1'b0, "R3 init_done stays low", init_done, 0);
    chk(in_ready == 1'b0 && cmd_ready == 1'b0, "R3 both ports closed", {in_ready, cmd_ready}, 0);
    chk(fptr == 1, "R3 only first byte consumed", fptr, 1);

    stream[0] = 8'h00;
    do_reset();
    hold = 1'b0;
    wait_init();
    chk(init_done == 1'b1, "R2 init_done after five bytes", init_done, 1);
    chk(fptr == 5, "R2 five bytes consumed by fill", fptr, 5);
    chk(finish_ok == (m_cod == 0), "R10 finish_ok with non-zero code", finish_ok, m_cod == 0);

    gap = 0;
    for (int p = 0; p < 2048; p += 7) do_bit(p);

    gap = 2;
    prob = 1024;
    for (int i = 0; i < 200; i++) begin
      do_bit(prob);
      prob = int'(rsp_prob);
    end

    gap = 3;
    for (int n = 0; n <= 32; n++) do_dir(n);
    do_dir(63);

    gap = 0;
    hold = 1'b1;
    p0 = fptr;
    send_cmd(1'b1, 0, 32);
    saw = 1'b0; stalled = 1'b0;
    repeat (40) begin
      @(negedge clk);
      if (rsp_done) saw = 1'b1;
      if (in_ready) stalled = 1'b1;
    end
    chk(!saw, "R8 no response while starved", saw, 0);
    chk(stalled, "R8 decoder waits for a byte", stalled, 1);
    chk(fptr == p0, "R8 no byte taken while held", fptr, p0);
    hold = 1'b0;
    get_rsp(ok);
    chk(ok, "R8 resumes after stall", ok, 1);
    begin
      logic [31:0] v, t;
      v = 0;
      for (int i = 0; i < 32; i++) begin
        m_norm();
        m_rng = m_rng >> 1;
        t = m_cod - m_rng;
        if (t[31]) v = v << 1;
        else begin m_cod = t; v = (v << 1) | 32'd1; end
      end
      chk(rsp_value == v, "R8 resumed run value", rsp_value, v);
      chk(fptr == m_ptr, "R8 bytes consumed after resume", fptr, m_ptr);
    end
    do_bit(1500);

    for (int i = 0; i < N; i++) stream[i] = 8'h00;
    do_reset();
    hold = 1'b0;
    wait_init();
    chk(finish_ok == 1'b1, "R10 finish_ok with zero code", finish_ok, 1);
    do_dir(8);
    chk(finish_ok == 1'b1, "R10 finish_ok after zero run", finish_ok, 1);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule